// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is a target on a two-wire serial bus (I2C / SMBus style) that gives a host controller access to a small bank of four byte-wide registers. It samples the raw SCL and SDA lines with the system clock and filters out short spikes on both. It then detects START and STOP conditions, shifts bytes in and out, and drives the acknowledge bit and read data onto SDA as an open-drain pull-down.

The target answers one fixed 7-bit address. In a write transfer, the first byte after the address is a command byte, and its low two bits are kept as a register pointer. Every byte after it produces a write strobe to the register named by the pointer. There is no auto-increment. The pointer stays where it is across bytes and across transfers, and only a new command byte moves it. A read is normally a write of the command byte, then a repeated START, then the address with the read bit set. The target then returns the selected register for each byte the host acknowledges. A read strobe is raised each time a byte is about to be loaded, so a register bank can capture fresh input levels.

The register bank sits outside this block. It sees the pointer, a write-data byte, a one-cycle write strobe and a one-cycle read strobe, and it returns the selected register on `reg_rdata` as combinational read data.

Top module: `i2c_ptr_target`

## Requirements
- R1: While reset is held and at its release, `sda_oe`, `reg_wr` and `reg_rd` are 0 and `reg_sel` is 0.
- R2: After a START, the target compares the first 7 received bits, MSB first, against the address 7'b1000001. The eighth bit is the direction bit (0 = write, 1 = read). On a match the target pulls SDA low for the ninth clock.
- R3: On an address that does not match, the target gives no acknowledge, issues no strobes and ignores all later bytes until the next START.
- R4: In a write transfer, the byte after the address is acknowledged and its bits [1:0] become `reg_sel`. Command values above 3 are accepted and use only those two bits.
- R5: Each byte after the command byte in a write transfer is acknowledged and produces exactly one `reg_wr` pulse, with `reg_wdata` equal to the byte and `reg_sel` equal to the pointer.
- R6: The pointer does not advance. Later data bytes, later transfers and reads all use the same register until a new command byte is received.
- R7: When a matching address with the read bit is acknowledged, one `reg_rd` pulse is issued. The next eight clocks then carry `reg_rdata`, MSB first, on SDA.
- R8: If the host acknowledges a read byte (SDA low on the ninth clock), the target issues another `reg_rd` and sends the same register again. If the host does not acknowledge, SDA is released and nothing more is sent.
- R9: A STOP at any point, including mid-byte, returns the target to idle without a strobe. A START at any point restarts address reception.
- R10: Pulses on SCL or SDA that last fewer than FILT_LEN system clocks after synchronization (5 clocks = 50 ns by default) have no effect on the bus protocol.
- R11: `reg_wr` and `reg_rd` are single-cycle pulses and are never high together.
- R12: SDA is pulled only in an acknowledge slot or in a read data bit, and it changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line level |
| sda_i | input | 1 | Raw serial data line level |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain enable) |
| reg_sel | output | SEL_W | Register pointer to the bank |
| reg_wdata | output | 8 | Byte to write into the selected register |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read/capture strobe |
| reg_rdata | input | 8 | Selected register contents from the bank |

## Verification
The hardest states to reach are those where a transfer is cut short. These include a STOP in the middle of a byte, a repeated START before the eighth bit, and spikes that fall inside the SCL-high window, where an SDA dip would otherwise look like a START. The bench drives the lines through an open-drain wired-AND model, with explicit quarter-bit phases. Inside those phases it inserts short SDA dips while SCL is high and short SCL pulses while SCL is low. It aborts bytes after a few bits and then checks through later reads that no register changed and that the pointer survived.

// File: rtl/i2c_tgt_pkg.sv
// Shared types for the register-pointer serial target.
// Assumes byte-wide transfers on the bus.
package i2c_tgt_pkg;

    localparam int BYTE_BITS = 8;

    // Protocol state of the target.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } tgt_state_e;

    // Meaning of the byte currently being received.
    typedef enum logic [1:0] {
        BK_ADDR,
        BK_CMD,
        BK_DATA
    } byte_kind_e;

endpackage

// File: rtl/i2c_glitch_filter.sv
// Synchronizes one bus line into the clock domain, then rejects any level
// change that does not persist for FILT_LEN consecutive clocks.
// Assumes the line idles high (pull-up); reset value is therefore 1.
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       stable_cnt;
    logic                   samp;

    assign samp = sync_q[SYNC_STAGES-1];

    // Metastability synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // Accept a new level only after it has held for FILT_LEN clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_cnt <= '0;
            line_o     <= 1'b1;
        end else if (samp == line_o) begin
            stable_cnt <= '0;
        end else if (stable_cnt == CNT_W'(FILT_LEN - 1)) begin
            line_o     <= samp;
            stable_cnt <= '0;
        end else begin
            stable_cnt <= stable_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
// Turns filtered SCL/SDA levels into one-cycle event flags: START, STOP,
// SCL rising and SCL falling. Assumes inputs are already glitch-free.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q, sda_q;

    // Previous-cycle copies of the filtered lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Edge and condition decode from previous and current levels.
    always_comb begin
        start_det = scl_f & scl_q & sda_q & ~sda_f;
        stop_det  = scl_f & scl_q & ~sda_q & sda_f;
        scl_rise  = scl_f & ~scl_q;
        scl_fall  = ~scl_f & scl_q;
    end
endmodule

// File: rtl/i2c_ptr_target.sv
// Serial-bus target with a fixed address and a sticky register pointer.
// Receives address, command and data bytes. Issues write and read strobes
// to an external bank and returns the selected register on reads.
// Assumes clk is fast enough that FILT_LEN plus a few cycles of latency
// fit well inside a quarter SCL period. No clock stretching.
module i2c_ptr_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR    = 7'b1000001,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 5,
    parameter int         SEL_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [SEL_W-1:0] reg_sel,
    output logic [7:0]       reg_wdata,
    output logic             reg_wr,
    output logic             reg_rd,
    input  logic [7:0]       reg_rdata
);
    localparam int BIT_W   = $clog2(BYTE_BITS + 1);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, flt_lines;
    logic               scl_flt, sda_flt;
    logic               start_det, stop_det, scl_rise, scl_fall;

    tgt_state_e         st;
    byte_kind_e         kind;
    logic [BIT_W-1:0]   bitcnt;
    logic [7:0]         rx_sh, tx_sh;
    logic               rw_q, mack_q;
    logic [SEL_W-1:0]   ptr;
    logic               byte_done, cmd_load;

    assign raw_lines = {scl_i, sda_i};

    // One filter per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        i2c_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(flt_lines[g])
        );
    end

    assign scl_flt = flt_lines[1];
    assign sda_flt = flt_lines[0];

    i2c_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_flt),
        .sda_f    (sda_flt),
        .start_det(start_det),
        .stop_det (stop_det),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    // Byte boundary flags for the receive path.
    assign byte_done = (st == ST_RX) && scl_fall && (bitcnt == BIT_W'(BYTE_BITS));
    assign cmd_load  = byte_done && (kind == BK_CMD);
    assign reg_sel   = ptr;

    // Protocol engine: shifting, acknowledge, strobes and pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            kind      <= BK_ADDR;
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            ptr       <= '0;
            sda_oe    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_rd    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_wr <= 1'b0;
            reg_rd <= 1'b0;
            if (stop_det) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else if (start_det) begin
                st     <= ST_RX;
                kind   <= BK_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh  <= {rx_sh[6:0], sda_flt};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_done) begin
                            case (kind)
                                BK_ADDR: begin
                                    if (rx_sh[7:1] == TGT_ADDR) begin
                                        sda_oe <= 1'b1;
                                        st     <= ST_RX_ACK;
                                        rw_q   <= rx_sh[0];
                                        reg_rd <= rx_sh[0];
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                BK_CMD: begin
                                    if (cmd_load) ptr <= rx_sh[SEL_W-1:0];
                                    sda_oe <= 1'b1;
                                    st     <= ST_RX_ACK;
                                end
                                default: begin
                                    reg_wr    <= 1'b1;
                                    reg_wdata <= rx_sh;
                                    sda_oe    <= 1'b1;
                                    st        <= ST_RX_ACK;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw_q && kind == BK_ADDR) begin
                                tx_sh  <= reg_rdata;
                                sda_oe <= ~reg_rdata[7];
                                st     <= ST_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_RX;
                                kind   <= (kind == BK_ADDR) ? BK_CMD : BK_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == BIT_W'(BYTE_BITS - 1)) begin
                                sda_oe <= 1'b0;
                                st     <= ST_TX_ACK;
                            end else begin
                                tx_sh  <= {tx_sh[6:0], 1'b0};
                                sda_oe <= ~tx_sh[6];
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) begin
                            mack_q <= ~sda_flt;
                            reg_rd <= ~sda_flt;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (mack_q) begin
                                tx_sh  <= reg_rdata;
                                sda_oe <= ~reg_rdata[7];
                                st     <= ST_TX;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_ptr_target_chk.sv
// Property checker for the register-pointer target, bound to every instance.
// Observes ports plus the filtered SCL level, the STOP flag and the
// command-load flag, which are driven by separate pieces of logic.
module i2c_ptr_target_chk #(
    parameter int SEL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sda_oe,
    input logic             reg_wr,
    input logic             reg_rd,
    input logic [SEL_W-1:0] reg_sel,
    input logic             scl_flt,
    input logic             stop_det,
    input logic             cmd_load
);
    // R11: strobes are exclusive.
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));

    // R11: write strobe lasts one cycle.
    p_wr_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);

    // R11: read strobe lasts one cycle.
    p_rd_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);

    // R5: a written byte is always acknowledged.
    p_wr_acked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> sda_oe);

    // R6: the pointer moves only after a command byte.
    p_sel_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_sel) |-> $past(cmd_load));

    // R9: STOP releases SDA and produces no write.
    p_stop_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !reg_wr));

    // R12: SDA drive changes only while SCL is low.
    p_sda_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_flt);
endmodule

bind i2c_ptr_target i2c_ptr_target_chk #(.SEL_W(SEL_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sda_oe  (sda_oe),
    .reg_wr  (reg_wr),
    .reg_rd  (reg_rd),
    .reg_sel (reg_sel),
    .scl_flt (scl_flt),
    .stop_det(stop_det),
    .cmd_load(cmd_load)
);

// File: tb/i2c_ptr_target_tb.sv
// Bench: bus-level host model driving an open-drain bus, behavioural
// register bank, and a scoreboard checking strobes on every clock.
module i2c_ptr_target_tb;
    localparam int Q = 25;            // quarter SCL bit, in clocks

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl_m, sda_m;
    logic       sda_bus;
    logic       sda_oe, reg_wr, reg_rd;
    logic [1:0] reg_sel;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] bank [4];
    logic [9:0] wq [$];
    int         n_chk = 0, n_fail = 0;
    int         rd_seen = 0, own_viol = 0;
    bit         own = 1'b0;
    logic [1:0] mptr = 2'd0;

    always #5 clk = ~clk;

    assign sda_bus   = sda_m & ~sda_oe;
    assign reg_rdata = bank[reg_sel];

    i2c_ptr_target u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .reg_sel  (reg_sel),
        .reg_wdata(reg_wdata),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural register bank.
    always @(posedge clk) begin
        if (!rst_n) for (int i = 0; i < 4; i++) bank[i] <= 8'h00;
        else if (reg_wr) bank[reg_sel] <= reg_wdata;
    end

    // Scoreboard, evaluated every clock away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (own && sda_oe) own_viol++;
            if (reg_wr && reg_rd) chk(0, "R11 both strobes", 1, 0);
            if (reg_wr) begin
                if (wq.size() == 0) chk(0, "R5 unexpected write", {reg_sel, reg_wdata}, 0);
                else begin
                    logic [9:0] e;
                    e = wq.pop_front();
                    chk({reg_sel, reg_wdata} == e, "R5 write sel/data", {reg_sel, reg_wdata}, e);
                end
            end
            if (reg_rd) begin
                rd_seen++;
                chk(reg_sel == mptr, "R6 read pointer", reg_sel, mptr);
            end
        end
    end

    task automatic hq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic do_start();
        sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
    endtask

    task automatic do_stop();
        sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq(); hq();
    endtask

    // glitch: 1 = SDA dip while SCL high, 2 = SCL pulse while SCL low
    task automatic put_bit(input logic b, input int glitch);
        hq(); sda_m = b; own = 1'b1;
        if (glitch == 2) begin
            scl_m = 1'b1; repeat (3) @(negedge clk); scl_m = 1'b0;
        end
        hq(); scl_m = 1'b1; hq();
        if (glitch == 1) begin
            sda_m = 1'b0; repeat (3) @(negedge clk); sda_m = b;
        end
        hq(); scl_m = 1'b0; own = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; hq(); hq(); scl_m = 1'b1; hq(); b = sda_bus; hq(); scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input int glitch, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i], (i == 7) ? glitch : 0);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            logic b;
            get_bit(b);
            d[i] = b;
        end
        put_bit(~mack, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic       a;
        logic [7:0] d;
        int         rd0;
        scl_m = 1'b1; sda_m = 1'b1; rst_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R1 sda_oe", sda_oe, 0);
        chk(reg_wr == 1'b0 && reg_rd == 1'b0, "R1 strobes", {reg_wr, reg_rd}, 0);
        chk(reg_sel == 2'd0, "R1 reg_sel", reg_sel, 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // Write: command 3, two data bytes to the same register.
        do_start();
        send_byte(8'h82, 0, a); chk(a, "R2 address ack", a, 1);
        send_byte(8'h03, 0, a); chk(a, "R4 command ack", a, 1); mptr = 2'd3;
        wq.push_back({2'd3, 8'hA5});
        send_byte(8'hA5, 0, a); chk(a, "R5 data ack", a, 1);
        wq.push_back({2'd3, 8'h3C});
        send_byte(8'h3C, 0, a); chk(a, "R6 second data ack", a, 1);
        do_stop(); repeat (20) @(negedge clk);
        chk(wq.size() == 0, "R6 both writes seen", wq.size(), 0);
        chk(own_viol == 0, "R12 no drive in host bits", own_viol, 0);

        // Write register 1.
        do_start();
        send_byte(8'h82, 0, a);
        send_byte(8'h01, 0, a); mptr = 2'd1;
        wq.push_back({2'd1, 8'h5A});
        send_byte(8'h5A, 0, a); chk(a, "R5 data ack reg1", a, 1);
        do_stop();

        // Read via repeated START, two bytes, then NACK.
        do_start();
        send_byte(8'h82, 0, a);
        send_byte(8'h01, 0, a);
        rd0 = rd_seen;
        do_start();
        send_byte(8'h83, 0, a); chk(a, "R7 read address ack", a, 1);
        chk(rd_seen == rd0 + 1, "R7 read strobe", rd_seen - rd0, 1);
        recv_byte(d, 1'b1); chk(d == 8'h5A, "R7 read data", d, 8'h5A);
        chk(rd_seen == rd0 + 2, "R8 strobe after host ack", rd_seen - rd0, 2);
        recv_byte(d, 1'b0); chk(d == 8'h5A, "R8 repeat same register", d, 8'h5A);
        hq(); hq();
        chk(sda_oe == 1'b0, "R8 released after NACK", sda_oe, 0);
        chk(rd_seen == rd0 + 2, "R8 no strobe after NACK", rd_seen - rd0, 2);
        do_stop();

        // Read without a command: pointer is sticky.
        do_start();
        send_byte(8'h83, 0, a);
        recv_byte(d, 1'b0); chk(d == 8'h5A, "R6 sticky pointer read", d, 8'h5A);
        do_stop();

        // Command above 3 uses its low two bits.
        do_start();
        send_byte(8'h82, 0, a);
        send_byte(8'h06, 0, a); chk(a, "R4 large command ack", a, 1); mptr = 2'd2;
        wq.push_back({2'd2, 8'h77});
        send_byte(8'h77, 0, a);
        do_start();
        send_byte(8'h83, 0, a);
        recv_byte(d, 1'b0); chk(d == 8'h77, "R4 low bits select reg2", d, 8'h77);
        do_stop();

        // Foreign addresses: no ack, no strobes.
        rd0 = rd_seen;
        do_start();
        send_byte(8'h84, 0, a); chk(!a, "R3 foreign write addr nack", a, 0);
        send_byte(8'hFF, 0, a); chk(!a, "R3 later byte ignored", a, 0);
        do_stop();
        do_start();
        send_byte(8'h85, 0, a); chk(!a, "R3 foreign read addr nack", a, 0);
        do_stop();
        chk(rd_seen == rd0, "R3 no read strobe", rd_seen - rd0, 0);
        chk(wq.size() == 0 && bank[2] == 8'h77, "R3 bank untouched", bank[2], 8'h77);

        // STOP mid-byte and repeated START mid-byte.
        do_start();
        send_byte(8'h82, 0, a);
        send_byte(8'h03, 0, a); mptr = 2'd3;
        put_bit(1'b1, 0); put_bit(1'b0, 0); put_bit(1'b1, 0); put_bit(1'b0, 0);
        do_stop();
        do_start();
        put_bit(1'b1, 0); put_bit(1'b0, 0); put_bit(1'b0, 0);
        do_start();
        send_byte(8'h82, 0, a); chk(a, "R9 restart mid-byte ack", a, 1);
        send_byte(8'h03, 0, a);
        do_start();
        send_byte(8'h83, 0, a);
        recv_byte(d, 1'b0); chk(d == 8'h3C, "R9 aborted byte not written", d, 8'h3C);
        do_stop();

        // Spikes on both lines are rejected.
        do_start();
        send_byte(8'h82, 0, a);
        send_byte(8'h01, 2, a); chk(a, "R10 SCL spike ignored", a, 1); mptr = 2'd1;
        wq.push_back({2'd1, 8'hC3});
        send_byte(8'hC3, 1, a); chk(a, "R10 SDA spike ignored", a, 1);
        do_stop();
        do_start();
        send_byte(8'h83, 0, a);
        recv_byte(d, 1'b0); chk(d == 8'hC3, "R10 data intact", d, 8'hC3);
        do_stop();
        repeat (20) @(negedge clk);
        chk(wq.size() == 0, "R5 all writes seen", wq.size(), 0);
        chk(own_viol == 0, "R12 final drive check", own_viol, 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule